// File: doc/BRIEF.md
# Infrared Mark/Space Width Capture

This block times the pulses on a demodulated infrared receiver line. The line idles high and is pulled low while a carrier is present, so a low level is a mark and a high level is a space. Each time the line changes level, the block emits a one-cycle strobe that carries the level of the interval that just ended (1 for a mark, 0 for a space) and that interval's length in microsecond ticks. A protocol decoder downstream consumes these pairs.

A single free-running tick counter provides the timing. It is cleared only when the line rises, which ends a mark. A falling edge reports the counter value directly as the space length and records that value. A rising edge reports the counter minus the recorded value as the mark length. A programmable timeout marks the end of a frame: when the counter reaches the programmed value while the line is idle, the block emits one timeout pulse.

Top module: `ir_pulse_capture`

## Requirements
- R1: While `en` is low, or after reset, `out_valid`, `out_level`, `out_dur` and `timeout_pulse` are all 0, and input edges produce no report.
- R2: `out_level` is 1 when the reported interval was a mark (line low) and 0 when it was a space (line high).
- R3: On a falling edge, `out_dur` equals the tick count accumulated since the last rising edge.
- R4: On a rising edge, `out_dur` equals the current tick count minus the count captured at the previous falling edge, computed modulo 2^CNT_W.
- R5: The tick counter is cleared on each rising edge, and falling edges do not clear it.
- R6: When the tick count equals `timeout_cfg` and the synchronized line is high, `timeout_pulse` is high for exactly one cycle, at most once per idle period.
- R7: No timeout pulse is raised while the synchronized line is low, even if the count equals `timeout_cfg`.
- R8: The timeout re-arms after any input edge, so each new idle period can raise its own pulse.
- R9: The tick counter stops at 2^CNT_W-2 and does not wrap. A space longer than that reports exactly 2^CNT_W-2, and the mark that follows reports 0.
- R10: A level change on `ir_in` appears as an `out_valid` strobe after the third rising clock edge that samples it: two synchronizer stages plus the output register.
- R11: The tick counter advances once every CLK_DIV clock cycles while `en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables capture; when low, clears all capture state |
| ir_in | input | 1 | Asynchronous receiver line, active low |
| timeout_cfg | input | CNT_W | Idle tick count that raises the timeout |
| out_valid | output | 1 | One-cycle strobe for a finished interval |
| out_level | output | 1 | 1 = mark, 0 = space |
| out_dur | output | CNT_W | Interval length in ticks |
| timeout_pulse | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with CLK_DIV=4 and CNT_W=8. With these values a tick lasts four clocks and the counter stops at 254. The saturation boundary, the mark of length 0 that follows a saturated space, and several timeout windows therefore all fit into a few thousand cycles. A behavioural model, which keeps the input history in a queue and timing in integers, predicts every output on every clock. Directed windows count timeout pulses while the line is idle and while it is held low.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    // Edge information derived from the synchronized line
    typedef struct packed {
        logic line_hi;   // synchronized level, 1 = idle/space
        logic rise;      // end of a mark
        logic fall;      // end of a space
    } ir_edge_t;

    typedef enum logic {
        LVL_SPACE = 1'b0,
        LVL_MARK  = 1'b1
    } ir_level_e;

    localparam int unsigned DEF_CLK_DIV     = 64;
    localparam int unsigned DEF_CNT_W       = 31;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Terminal count for a counter of the given width
    function automatic logic [63:0] term_count(input int unsigned w);
        return (64'd1 << w) - 64'd2;
    endfunction

endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge
    import ir_cap_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ir_in,
    output ir_edge_t ev
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], ir_in};
    end

    always_comb begin
        ev.line_hi = chain[STAGES-1];
        ev.rise    =  chain[STAGES-1] & ~chain[STAGES];
        ev.fall    = ~chain[STAGES-1] &  chain[STAGES];
    end
endmodule

// File: rtl/ir_us_tick.sv
module ir_us_tick #(
    parameter int unsigned CLK_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || !en)       pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + 1'b1;
    end

    assign tick = en && (pre == LAST);
endmodule

// File: rtl/ir_span_counter.sv
module ir_span_counter
    import ir_cap_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(term_count(CNT_W));

    always_ff @(posedge clk) begin
        if (rst || !en)                    cnt <= '0;
        else if (clear)                    cnt <= '0;
        else if (tick && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ir_capture_unit.sv
module ir_capture_unit
    import ir_cap_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ir_edge_t         ev,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] timeout_cfg,
    output logic             out_valid,
    output logic             out_level,
    output logic [CNT_W-1:0] out_dur,
    output logic             timeout_pulse,
    output logic [CNT_W-1:0] prev_fall
);
    logic armed;
    logic any_edge;
    logic to_fire;

    assign any_edge = ev.rise | ev.fall;
    assign to_fire  = armed && !any_edge && ev.line_hi && (cnt == timeout_cfg);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            out_valid     <= 1'b0;
            out_level     <= LVL_SPACE;
            out_dur       <= '0;
            timeout_pulse <= 1'b0;
            prev_fall     <= '0;
            armed         <= 1'b1;
        end else begin
            out_valid     <= any_edge;
            out_level     <= ev.rise ? LVL_MARK : LVL_SPACE;
            timeout_pulse <= to_fire;
            if (ev.fall) begin
                out_dur   <= cnt;
                prev_fall <= cnt;
            end else if (ev.rise) begin
                out_dur   <= cnt - prev_fall;
            end
            if (any_edge)     armed <= 1'b1;
            else if (to_fire) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int unsigned CLK_DIV     = DEF_CLK_DIV,
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ir_in,
    input  logic [CNT_W-1:0] timeout_cfg,
    output logic             out_valid,
    output logic             out_level,
    output logic [CNT_W-1:0] out_dur,
    output logic             timeout_pulse
);
    ir_edge_t         ev;
    logic             tick;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] prev_fall_val;
    logic             line_hi;

    assign line_hi = ev.line_hi;

    ir_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ir_in(ir_in), .ev(ev)
    );

    ir_us_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .en(en), .tick(tick)
    );

    ir_span_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .clear(ev.rise), .tick(tick), .cnt(cnt_val)
    );

    ir_capture_unit #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .en(en), .ev(ev), .cnt(cnt_val),
        .timeout_cfg(timeout_cfg), .out_valid(out_valid), .out_level(out_level),
        .out_dur(out_dur), .timeout_pulse(timeout_pulse), .prev_fall(prev_fall_val)
    );
endmodule

// File: rtl/ir_capture_checker.sv
module ir_capture_checker
    import ir_cap_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] timeout_cfg,
    input logic             out_valid,
    input logic             out_level,
    input logic [CNT_W-1:0] out_dur,
    input logic             timeout_pulse,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] prev_fall_q,
    input logic             line_hi
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(term_count(CNT_W));

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!out_valid && !timeout_pulse)); // R1
    AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_level) |-> (out_dur == prev_fall_q)); // R3
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_level) |-> (cnt_q == '0)); // R5
    AST_TO_MATCH: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> ($past(cnt_q) == $past(timeout_cfg))); // R6
    AST_TO_ONCE: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse); // R6
    AST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> $past(line_hi)); // R7
    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX); // R9
endmodule

bind ir_pulse_capture ir_capture_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .timeout_cfg(timeout_cfg),
    .out_valid(out_valid), .out_level(out_level), .out_dur(out_dur),
    .timeout_pulse(timeout_pulse), .cnt_q(cnt_val), .prev_fall_q(prev_fall_val),
    .line_hi(line_hi)
);

// File: tb/sim_ir_pulse_capture.sv
module sim_ir_pulse_capture;
    localparam int DIV   = 4;
    localparam int W     = 8;
    localparam int MAXC  = (1 << W) - 2;
    localparam int MOD   = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         ir_in = 1'b1;
    logic [W-1:0] timeout_cfg = 8'd40;
    logic         out_valid, out_level, timeout_pulse;
    logic [W-1:0] out_dur;

    always #5 clk = ~clk;

    ir_pulse_capture #(.CLK_DIV(DIV), .CNT_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .en(en), .ir_in(ir_in), .timeout_cfg(timeout_cfg),
        .out_valid(out_valid), .out_level(out_level), .out_dur(out_dur),
        .timeout_pulse(timeout_pulse)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    to_count = 0;
    int    valid_count = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    bit q[$];
    int m_pre = 0, m_cnt = 0, m_prevf = 0;
    bit m_armed = 1;
    bit e_valid = 0, e_level = 0, e_to = 0;
    int e_dur = 0;

    always @(posedge clk) begin
        if (rst) begin
            q = '{1, 1, 1};
            m_pre = 0; m_cnt = 0; m_prevf = 0; m_armed = 1;
            e_valid = 0; e_level = 0; e_to = 0; e_dur = 0;
        end else begin
            bit now_l, old_l, r, f, t;
            int c_old;
            q.push_front(ir_in);
            now_l = q[2];
            old_l = q[3];
            void'(q.pop_back());
            if (!en) begin
                m_pre = 0; m_cnt = 0; m_prevf = 0; m_armed = 1;
                e_valid = 0; e_level = 0; e_to = 0; e_dur = 0;
            end else begin
                r = now_l && !old_l;
                f = !now_l && old_l;
                c_old = m_cnt;
                e_valid = r || f;
                e_level = r;
                e_to = m_armed && !r && !f && now_l && (c_old == int'(timeout_cfg));
                if (f) begin e_dur = c_old; m_prevf = c_old; end
                else if (r) e_dur = (c_old - m_prevf + MOD) % MOD;
                t = (m_pre == DIV - 1);
                m_pre = t ? 0 : m_pre + 1;
                if (r) m_cnt = 0;
                else if (t && m_cnt < MAXC) m_cnt = m_cnt + 1;
                if (r || f) m_armed = 1;
                else if (e_to) m_armed = 0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (timeout_pulse) to_count++;
            if (out_valid) valid_count++;
            check(out_valid == e_valid, {cur_req, " valid"}, out_valid, e_valid);
            check(timeout_pulse == e_to, {cur_req, " timeout"}, timeout_pulse, e_to);
            if (e_valid) begin
                check(out_level == e_level, "R2 level", out_level, e_level);
                check(int'(out_dur) == e_dur, {cur_req, " duration"}, out_dur, e_dur);
            end
        end
    end

    task automatic hold(bit lvl, int n);
        ir_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    // drive a level and return the report that follows it
    task automatic edge_report(bit lvl, output int dur, output bit lev, output int lat);
        ir_in = lvl;
        lat = 0;
        dur = -1;
        lev = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lat++;
            if (out_valid) begin
                dur = out_dur;
                lev = out_level;
                break;
            end
        end
    endtask

    task automatic scenario;
        int d, lat, t0, v0;
        bit l;
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        check(out_valid == 0 && timeout_pulse == 0 && out_dur == 0, "R1 reset outputs", out_dur, 0);
        v0 = valid_count;
        hold(0, 30); hold(1, 30); hold(0, 10); hold(1, 20);
        check(valid_count == v0, "R1 edges ignored while disabled", valid_count - v0, 0);

        en = 1'b1;
        hold(1, 20);
        cur_req = "R10";
        edge_report(0, d, l, lat);
        check(lat == 3, "R10 latency", lat, 3);
        check(l == 0, "R2 space level", l, 0);
        hold(0, 36);
        edge_report(1, d, l, lat);
        check(l == 1, "R2 mark level", l, 1);
        hold(1, 40);
        cur_req = "R11";
        edge_report(0, d, l, lat);
        check(d >= 10 && d <= 12, "R11 tick rate space", d, 11);

        cur_req = "R3 R4 R5";
        for (int k = 1; k <= 6; k++) begin
            hold(0, 8 * k + 3);
            hold(1, 12 * k + 1);
        end
        hold(0, 17); hold(1, 5); hold(0, 50); hold(1, 9);

        cur_req = "R6";
        timeout_cfg = 8'd40;
        hold(1, 20);
        t0 = to_count;
        hold(1, 400);
        check(to_count - t0 == 1, "R6 single timeout per idle", to_count - t0, 1);

        cur_req = "R7";
        hold(0, 20); hold(1, 20);
        hold(0, 8);
        t0 = to_count;
        hold(0, 300);
        check(to_count == t0, "R7 no timeout while low", to_count - t0, 0);
        cur_req = "R8";
        t0 = to_count;
        hold(1, 400);
        check(to_count - t0 == 1, "R8 re-armed after edge", to_count - t0, 1);

        cur_req = "R9";
        timeout_cfg = 8'd200;
        hold(1, 1200);
        edge_report(0, d, l, lat);
        check(d == MAXC, "R9 saturated space", d, MAXC);
        hold(0, 20);
        edge_report(1, d, l, lat);
        check(d == 0, "R9 mark after saturation", d, 0);

        cur_req = "R1";
        hold(1, 30);
        hold(0, 12);
        en = 1'b0;
        v0 = valid_count;
        hold(1, 15); hold(0, 15); hold(1, 15);
        check(valid_count == v0 && out_valid == 0, "R1 disable mid-frame", valid_count - v0, 0);
        en = 1'b1;
        cur_req = "R3 R4";
        hold(1, 30); hold(0, 26); hold(1, 44); hold(0, 14); hold(1, 20);
    endtask

    initial begin
        bit wd = 0;
        fork
            scenario();
            begin
                repeat (20000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule